// File: doc/BRIEF.md
# Configurable Byte-wise CRC Engine

This block keeps a running cyclic redundancy check over a stream of bytes fed one per command. A command carries a mode code and one data byte; the engine folds the byte into a 32-bit result register with either one of four built-in generator polynomials (8, 16, 24 or 32 bits wide) or a polynomial that software programs together with its width, anywhere from 1 to 32 bits.

The built-in modes finish in one clock. The programmable mode reuses one narrow bit-serial datapath over three clocks. While it runs, `busy_o` is high and the command port stalls. Software seeds the CRC by writing the result register. A write that lands in the same cycle as a command is used as that command's starting value. Every update pulses `done_o`. One configuration input picks whether a byte enters least-significant bit first or most-significant bit first. There is no final XOR and no output reflection.

Top module: `crc_engine`

## Requirements
- R1: Mode codes 0, 1, 2 and 3 select CRC widths 8, 16, 24 and 32 with polynomials 0x07, 0x8005, 0x864CFB and 0x04C11DB7. The CRC is not reflected, has no final XOR, and the register shifts toward its top bit, which is bit width-1.
- R2: Each accepted command (`cmd_valid_i` high while `cmd_ready_o` is high) consumes exactly one byte, `cmd_data_i`, and updates the result register once.
- R3: A built-in mode update is visible on `res_o` in the cycle after acceptance. `done_o` is high in that same cycle.
- R4: A mode code with bit 2 set selects the programmable mode, which uses the configured polynomial and width. A width write is accepted only for values 1 to 32; any other value is ignored. After reset the width is 32 and the polynomial is 0x04C11DB7.
- R5: A programmable-mode update keeps `busy_o` high for the three cycles after acceptance. In the fourth cycle `busy_o` is low, `done_o` is high and `res_o` holds the new CRC.
- R6: While `busy_o` is high, `cmd_ready_o` is low and commands stall. Result, polynomial and width writes are ignored.
- R7: After any update, the result bits at and above the active width read as zero.
- R8: With `cfg_lsb_first_i` high, bit 0 of the byte enters first. With it low, bit 7 enters first.
- R9: A result write while idle seeds the CRC and is visible on `res_o` the next cycle. A command accepted in the same cycle starts from the written value.
- R10: Reset clears the result register to zero, clears `busy_o` and `done_o`, and raises `cmd_ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Update command present |
| cmd_mode_i | input | 3 | Mode code: 0-3 built-in widths, bit 2 set for programmable |
| cmd_data_i | input | 8 | Byte to fold into the CRC |
| cmd_ready_o | output | 1 | Engine can take a command this cycle |
| res_we_i | input | 1 | Result register write strobe |
| res_wdata_i | input | 32 | Seed value |
| res_o | output | 32 | Current CRC |
| cfg_poly_we_i | input | 1 | Programmable polynomial write strobe |
| cfg_poly_i | input | 32 | Programmable polynomial coefficients |
| cfg_width_we_i | input | 1 | Programmable width write strobe |
| cfg_width_i | input | 6 | Programmable width, 1 to 32 |
| cfg_lsb_first_i | input | 1 | Byte bit order select |
| busy_o | output | 1 | Programmable update in progress |
| done_o | output | 1 | One-cycle pulse after an update lands |

## Verification
The assertions check several properties on every cycle. A built-in update raises `done_o` one cycle after acceptance. A programmable update holds `busy_o` for exactly three cycles. The result and the configuration registers stay frozen while busy, except on the finishing edge. The bits above the active width are zero whenever `done_o` is high. Only the bench's scenarios can show that the CRC values themselves are right. It checks catalogue check values for all four built-in widths, a reflected-input case, and a narrow programmable width. It also checks that a seed written in the same cycle as a command is used, and that writes attempted while busy leave no trace in later results.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int CRC_W        = 32;
  localparam int BYTE_W       = 8;
  localparam int WIDTH_W      = $clog2(CRC_W) + 1;
  localparam int NUM_FIXED    = 4;
  localparam int CUST_STAGES  = 3;
  localparam int BITS_PER_STG = (BYTE_W + CUST_STAGES - 1) / CUST_STAGES;
  localparam int CNT_W        = $clog2(CUST_STAGES);

  localparam logic [NUM_FIXED-1:0][CRC_W-1:0] FIXED_POLY =
    {32'h04C1_1DB7, 32'h0086_4CFB, 32'h0000_8005, 32'h0000_0007};

  localparam logic [CRC_W-1:0]   RST_POLY  = 32'h04C1_1DB7;
  localparam logic [WIDTH_W-1:0] RST_WIDTH = WIDTH_W'(CRC_W);

  function automatic logic [WIDTH_W-1:0] fixed_width(input logic [1:0] sel);
    return {1'b0, sel, 3'b000} + WIDTH_W'(8);
  endfunction

  function automatic logic [CRC_W-1:0] width_mask(input logic [WIDTH_W-1:0] w);
    if (w >= WIDTH_W'(CRC_W)) return '1;
    return (CRC_W'(1) << w) - CRC_W'(1);
  endfunction

  // fold bits [first,last) of the byte, in selected order, into crc
  function automatic logic [CRC_W-1:0] crc_feed(
    input logic [CRC_W-1:0]   crc,
    input logic [BYTE_W-1:0]  data,
    input int                 first,
    input int                 last,
    input logic               lsb_first,
    input logic [CRC_W-1:0]   poly,
    input logic [WIDTH_W-1:0] w
  );
    logic [CRC_W-1:0] m;
    logic [CRC_W-1:0] c;
    logic [4:0]       top;
    logic             b;
    logic             fb;
    m   = width_mask(w);
    top = 5'(w - WIDTH_W'(1));
    c   = crc & m;
    for (int i = 0; i < BYTE_W; i++) begin
      if (i >= first && i < last) begin
        b  = lsb_first ? data[i] : data[BYTE_W-1-i];
        fb = c[top] ^ b;
        c  = (c << 1) & m;
        if (fb) c = c ^ (poly & m);
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/crc_fixed_path.sv
module crc_fixed_path
  import crc_pkg::*;
(
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [1:0]        sel_i,
  input  logic              lsb_first_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] lane [NUM_FIXED];

  for (genvar g = 0; g < NUM_FIXED; g++) begin : g_lane
    assign lane[g] = crc_feed(crc_i, data_i, 0, BYTE_W, lsb_first_i,
                              FIXED_POLY[g], fixed_width(2'(g)));
  end

  assign crc_o = lane[sel_i];
endmodule

// File: rtl/crc_custom_seq.sv
module crc_custom_seq
  import crc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CRC_W-1:0]   crc_i,
  input  logic [BYTE_W-1:0]  data_i,
  input  logic [CRC_W-1:0]   poly_i,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic               lsb_first_i,
  output logic               busy_o,
  output logic               finish_o,
  output logic [CRC_W-1:0]   crc_o
);
  logic               busy_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CRC_W-1:0]   work_q, poly_q, work_d;
  logic [BYTE_W-1:0]  data_q;
  logic [WIDTH_W-1:0] width_q;
  logic               lsb_q;
  int                 first_s, last_s;

  always_comb begin
    first_s = (CUST_STAGES - 1 - int'(cnt_q)) * BITS_PER_STG;
    last_s  = first_s + BITS_PER_STG;
    if (last_s > BYTE_W) last_s = BYTE_W;
    work_d  = crc_feed(work_q, data_q, first_s, last_s, lsb_q, poly_q, width_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      work_q  <= '0;
      poly_q  <= '0;
      data_q  <= '0;
      width_q <= RST_WIDTH;
      lsb_q   <= 1'b0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      cnt_q   <= CNT_W'(CUST_STAGES - 1);
      work_q  <= crc_i;
      poly_q  <= poly_i;
      data_q  <= data_i;
      width_q <= width_i;
      lsb_q   <= lsb_first_i;
    end else if (busy_q) begin
      work_q <= work_d;
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o   = busy_q;
  assign finish_o = busy_q && (cnt_q == '0);
  assign crc_o    = work_d;

  a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  a_r5_one_finish: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |=> !finish_o);
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_mode_i,
  input  logic [BYTE_W-1:0]  cmd_data_i,
  output logic               cmd_ready_o,
  input  logic               res_we_i,
  input  logic [CRC_W-1:0]   res_wdata_i,
  output logic [CRC_W-1:0]   res_o,
  input  logic               cfg_poly_we_i,
  input  logic [CRC_W-1:0]   cfg_poly_i,
  input  logic               cfg_width_we_i,
  input  logic [WIDTH_W-1:0] cfg_width_i,
  input  logic               cfg_lsb_first_i,
  output logic               busy_o,
  output logic               done_o
);
  logic [CRC_W-1:0]   crc_q, poly_q, seed, fixed_crc, seq_crc;
  logic [WIDTH_W-1:0] width_q, last_w_q;
  logic               done_q, busy, seq_finish, accept, is_cust, width_ok;

  assign is_cust  = cmd_mode_i[2];
  assign accept   = cmd_valid_i && !busy;
  assign seed     = res_we_i ? res_wdata_i : crc_q;
  assign width_ok = (cfg_width_i != '0) && (cfg_width_i <= WIDTH_W'(CRC_W));

  crc_fixed_path u_fixed (
    .crc_i       (seed),
    .data_i      (cmd_data_i),
    .sel_i       (cmd_mode_i[1:0]),
    .lsb_first_i (cfg_lsb_first_i),
    .crc_o       (fixed_crc)
  );

  crc_custom_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept && is_cust),
    .crc_i       (seed),
    .data_i      (cmd_data_i),
    .poly_i      (poly_q),
    .width_i     (width_q),
    .lsb_first_i (cfg_lsb_first_i),
    .busy_o      (busy),
    .finish_o    (seq_finish),
    .crc_o       (seq_crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q    <= '0;
      poly_q   <= RST_POLY;
      width_q  <= RST_WIDTH;
      last_w_q <= RST_WIDTH;
      done_q   <= 1'b0;
    end else begin
      done_q <= seq_finish || (accept && !is_cust);
      if (seq_finish)                crc_q <= seq_crc;
      else if (accept && !is_cust)   crc_q <= fixed_crc;
      else if (res_we_i && !busy)    crc_q <= res_wdata_i;
      if (accept) last_w_q <= is_cust ? width_q : fixed_width(cmd_mode_i[1:0]);
      if (!busy && cfg_poly_we_i)             poly_q  <= cfg_poly_i;
      if (!busy && cfg_width_we_i && width_ok) width_q <= cfg_width_i;
    end
  end

  assign cmd_ready_o = !busy;
  assign res_o       = crc_q;
  assign busy_o      = busy;
  assign done_o      = done_q;

  a_r3_fixed_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !is_cust) |=> (done_o && !busy_o));
  a_r5_cust_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_cust) |=> busy_o ##1 busy_o ##1 busy_o ##1 (!busy_o && done_o));
  a_r6_res_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !seq_finish) |=> $stable(res_o));
  a_r6_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(poly_q) && $stable(width_q)));
  a_r7_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((res_o & ~width_mask(last_w_q)) == '0));
  a_r4_width_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_q != '0) && (width_q <= WIDTH_W'(CRC_W)));
endmodule

// File: tb/crc_engine_test.sv
module crc_engine_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [2:0]  cmd_mode_i = '0;
  logic [7:0]  cmd_data_i = '0;
  logic        cmd_ready_o;
  logic        res_we_i = 1'b0;
  logic [31:0] res_wdata_i = '0;
  logic [31:0] res_o;
  logic        cfg_poly_we_i = 1'b0;
  logic [31:0] cfg_poly_i = '0;
  logic        cfg_width_we_i = 1'b0;
  logic [5:0]  cfg_width_i = '0;
  logic        cfg_lsb_first_i = 1'b0;
  logic        busy_o, done_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_crc = '0, m_poly = 32'h04C11DB7;
  int          m_width = 32;

  always #10 clk_i = ~clk_i;

  crc_engine uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_byte(logic [31:0] s, logic [7:0] d, int w,
                                           logic [31:0] p, bit lsb);
    logic [31:0] m, r;
    bit src, msb;
    m = (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    r = s & m;
    for (int j = 0; j < 8; j++) begin
      src = lsb ? d[j] : d[7-j];
      msb = r[w-1];
      r = (r << 1) & m;
      if (msb ^ src) r = r ^ (p & m);
    end
    return r;
  endfunction

  // driver: issue one command, push expected result
  task automatic send(logic [2:0] mode, logic [7:0] d, string req,
                      bit seed_en = 0, logic [31:0] seed_v = '0);
    int w;
    logic [31:0] p;
    @(negedge clk_i);
    while (!cmd_ready_o) @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_mode_i = mode; cmd_data_i = d;
    res_we_i = seed_en; res_wdata_i = seed_v;
    if (seed_en) m_crc = seed_v;
    w = mode[2] ? m_width : 8 * (int'(mode[1:0]) + 1);
    p = mode[2] ? m_poly :
        (mode[1:0] == 2'd0) ? 32'h07 : (mode[1:0] == 2'd1) ? 32'h8005 :
        (mode[1:0] == 2'd2) ? 32'h864CFB : 32'h04C11DB7;
    m_crc = ref_byte(m_crc, d, w, p, cfg_lsb_first_i);
    exp_q.push_back(m_crc); tag_q.push_back(req);
    @(negedge clk_i);
    cmd_valid_i = 1'b0; res_we_i = 1'b0;
  endtask

  task automatic seed(logic [31:0] v);
    @(negedge clk_i);
    while (!cmd_ready_o) @(negedge clk_i);
    res_we_i = 1'b1; res_wdata_i = v;
    @(negedge clk_i);
    res_we_i = 1'b0;
    m_crc = v;
    check("R9 seed visible", res_o, v);
  endtask

  task automatic cfg(logic [31:0] p, logic [5:0] w);
    @(negedge clk_i);
    while (!cmd_ready_o) @(negedge clk_i);
    cfg_poly_we_i = 1'b1; cfg_poly_i = p;
    cfg_width_we_i = 1'b1; cfg_width_i = w;
    m_poly = p;
    if (w >= 1 && w <= 32) m_width = int'(w);
    @(negedge clk_i);
    cfg_poly_we_i = 1'b0; cfg_width_we_i = 1'b0;
  endtask

  task automatic feed_check_str(logic [2:0] mode, string req);
    string s;
    s = "123456789";
    for (int i = 0; i < 9; i++) send(mode, s[i], req);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor: compare each landed result against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected done actual=%h expected=none", res_o);
      end else begin
        check(tag_q.pop_front(), res_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 res reset", res_o, 32'h0);
    check("R10 busy reset", {31'b0, busy_o}, 32'h0);
    check("R10 done reset", {31'b0, done_o}, 32'h0);
    check("R10 ready reset", {31'b0, cmd_ready_o}, 32'h1);

    // R1 catalogue check values, R2 per-byte scoreboard
    seed(32'h0);
    feed_check_str(3'd0, "R2 crc8 byte");
    drain(); check("R1 crc8 check", res_o, 32'h0000_00F4);
    seed(32'h0);
    feed_check_str(3'd1, "R2 crc16 byte");
    drain(); check("R1 crc16 check", res_o, 32'h0000_FEE8);
    seed(32'h00B7_04CE);
    feed_check_str(3'd2, "R2 crc24 byte");
    drain(); check("R1 crc24 check", res_o, 32'h0021_CF02);
    seed(32'hFFFF_FFFF);
    feed_check_str(3'd3, "R2 crc32 byte");
    drain(); check("R1 crc32 check", res_o, 32'h0376_E6E7);

    // R3 one-cycle latency
    send(3'd3, 8'hA5, "R3 fixed value");
    check("R3 done next cycle", {31'b0, done_o}, 32'h1);
    check("R3 not busy", {31'b0, busy_o}, 32'h0);
    drain();

    // R8 lsb-first
    cfg_lsb_first_i = 1'b1;
    seed(32'h0);
    feed_check_str(3'd1, "R8 lsb byte");
    drain(); check("R8 lsb-first crc16", res_o, 32'h0000_BCDD);
    cfg_lsb_first_i = 1'b0;

    // R4 custom at width 32 matches built-in crc32
    seed(32'hFFFF_FFFF);
    feed_check_str(3'd4, "R4 custom32 byte");
    drain(); check("R4 custom32 check", res_o, 32'h0376_E6E7);

    // R4 narrow width, R7 upper bits zero
    cfg(32'h0000_0005, 6'd5);
    seed(32'hFFFF_FFFF);
    send(3'd4, 8'h3C, "R4 custom5");
    drain();
    check("R7 upper bits zero", res_o & 32'hFFFF_FFE0, 32'h0);
    cfg(32'h0000_0005, 6'd0);
    send(3'd4, 8'h81, "R4 width 0 ignored");
    cfg(32'h0000_0005, 6'd40);
    send(3'd4, 8'h7E, "R4 width 40 ignored");
    drain();

    // R5 latency, R6 stall and ignored writes
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_mode_i = 3'd4; cmd_data_i = 8'h5A;
    m_crc = ref_byte(m_crc, 8'h5A, m_width, m_poly, 1'b0);
    exp_q.push_back(m_crc); tag_q.push_back("R6 busy writes ignored");
    @(negedge clk_i);
    check("R5 busy cycle 1", {31'b0, busy_o}, 32'h1);
    check("R6 ready low", {31'b0, cmd_ready_o}, 32'h0);
    cmd_mode_i = 3'd0; cmd_data_i = 8'hFF;
    res_we_i = 1'b1; res_wdata_i = 32'hDEAD_BEEF;
    cfg_poly_we_i = 1'b1; cfg_poly_i = 32'h1F;
    cfg_width_we_i = 1'b1; cfg_width_i = 6'd12;
    @(negedge clk_i);
    check("R5 busy cycle 2", {31'b0, busy_o}, 32'h1);
    cmd_valid_i = 1'b0; res_we_i = 1'b0;
    cfg_poly_we_i = 1'b0; cfg_width_we_i = 1'b0;
    @(negedge clk_i);
    check("R5 busy cycle 3", {31'b0, busy_o}, 32'h1);
    @(negedge clk_i);
    check("R5 busy dropped", {31'b0, busy_o}, 32'h0);
    check("R5 done after three", {31'b0, done_o}, 32'h1);
    send(3'd4, 8'hC3, "R6 config kept after busy");
    drain();

    // R9 seed in the same cycle as a command
    send(3'd1, 8'h12, "R9 same-cycle seed", 1, 32'h0000_1D0F);
    send(3'd4, 8'h34, "R9 same-cycle seed custom", 1, 32'h0000_0011);
    drain();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule